// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received frames as a byte stream and stores each one in the buffer of the next free slot of a 256-slot receive ring. Every slot owns a fixed 2048-byte region of the memory behind the write port, so the buffer address is the slot number times 2048 plus the byte offset. The stream has no backpressure: a byte is taken on every cycle that `rx_valid_i` is high.

When a frame completes, the block writes the frame length and status into that slot's descriptor word. It then advances a 16-bit producer index. Software reads descriptor words through a separate read port and returns buffers by writing a new consumer index. There are two cases where the block drops a frame and commits nothing: the ring is full, or the frame is longer than the maximum length. A full ring also bumps an overflow counter. A header-alignment option moves the frame two bytes into its buffer. A pause request output follows the number of free slots, with hysteresis.

The producer index starts from a non-zero reset value (default 0xFFF0), and the consumer index starts from the same value. Software must align to the producer rather than assume zero. The 16-bit index wrap is therefore reached early in operation.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset, `prod_idx_o` equals 0xFFF0, `xoff_o` is 0 and `ovf_cnt_o` is 0.
- R2: Byte i of an accepted frame is written once to `mem_addr_o` = slot*2048 + i (+2 when aligned), where slot is the low 8 bits of `prod_idx_o` at the frame's first byte. It is written in the cycle that byte is presented.
- R3: With alignment enabled, data starts at offset 2, offsets 0 and 1 are not written, and the reported length is the byte count plus 2.
- R4: On commit, descriptor word [slot] reads back with bits 27:16 = reported length, bit 14 (end of frame) = 1 and bit 13 (start of frame) = 1. All other bits are 0.
- R5: Each committed frame raises `prod_idx_o` by exactly 1, modulo 65536, on the clock edge that takes the last byte. It wraps from 0xFFFF to 0x0000.
- R6: When `prod_idx_o` minus the consumer index (16-bit) equals 256 at a frame's first byte, the frame causes no memory write and no producer change, and `ovf_cnt_o` rises by 1.
- R7: A frame of up to 1536 bytes (pad excluded) is accepted. A longer frame writes its first 1536 bytes, commits nothing and leaves `prod_idx_o` unchanged.
- R8: Free slots = 256 - (producer - consumer). `xoff_o` goes to 1 one cycle after free <= 5, and returns to 0 one cycle after free >= 16. Between those values it holds.
- R9: The alignment input is sampled only at a frame's first byte. Changing it later in the frame has no effect on offsets or length.
- R10: A consumer write (`cons_wr_i`) loads `cons_idx_i` as the new consumer index, which frees slots for R6 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Stream byte valid |
| rx_data_i | input | 8 | Stream byte |
| rx_last_i | input | 1 | Last byte of frame |
| align_en_i | input | 1 | Two-byte header alignment enable |
| cons_wr_i | input | 1 | Consumer index write strobe |
| cons_idx_i | input | 16 | New consumer index |
| desc_idx_i | input | 8 | Descriptor read slot |
| mem_we_o | output | 1 | Buffer memory write enable |
| mem_addr_o | output | 19 | Buffer memory byte address |
| mem_data_o | output | 8 | Buffer memory write data |
| desc_word_o | output | 32 | Descriptor length/status word of slot `desc_idx_i` |
| prod_idx_o | output | 16 | Producer index |
| xoff_o | output | 1 | Pause request (flow control) |
| ovf_cnt_o | output | 16 | Count of frames dropped for a full ring |

## Verification
The hardest state to reach is a completely full ring, because it needs 256 committed frames and no consumer writes. Only then do the pause hysteresis and the overflow drop show up. The stimulus fills the ring with many short frames of random length and alignment, and checks `xoff_o` after every frame as the free count falls through 16 and 5 to 0. Next it offers one more frame and confirms the drop. Finally it returns slots in two steps, so the count stops between the thresholds before it reaches 16. The index starts at 0xFFF0, so this same fill also crosses the 16-bit wrap. A random phase with interleaved consumer writes follows.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  localparam int LEN_W   = 12;
  localparam int LEN_LSB = 16;
  localparam int EOF_BIT = 14;
  localparam int SOF_BIT = 13;

  function automatic logic [31:0] pack_status(input logic [LEN_W-1:0] len);
    logic [31:0] w;
    w = '0;
    w[LEN_LSB +: LEN_W] = len;
    w[EOF_BIT] = 1'b1;
    w[SOF_BIT] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/rx_idx_ctrl.sv
module rx_idx_ctrl #(
  parameter int              RING     = 256,
  parameter int              IDX_W    = 16,
  parameter int              XOFF_LO  = 5,
  parameter int              XON_HI   = 16,
  parameter logic [IDX_W-1:0] PROD_RST = 16'hFFF0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic             cons_wr_i,
  input  logic [IDX_W-1:0] cons_idx_i,
  output logic [IDX_W-1:0] prod_o,
  output logic             full_o,
  output logic             xoff_o
);
  localparam logic [IDX_W:0] RING_L = (IDX_W+1)'(RING);
  localparam logic [IDX_W:0] LO_L   = (IDX_W+1)'(XOFF_LO);
  localparam logic [IDX_W:0] HI_L   = (IDX_W+1)'(XON_HI);

  logic [IDX_W-1:0] prod_q, cons_q, used;
  logic [IDX_W:0]   free;
  logic             xoff_q;

  assign used   = prod_q - cons_q;
  assign free   = RING_L - {1'b0, used};
  assign full_o = {1'b0, used} >= RING_L;
  assign prod_o = prod_q;
  assign xoff_o = xoff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= PROD_RST;
      cons_q <= PROD_RST;
      xoff_q <= 1'b0;
    end else begin
      if (commit_i)  prod_q <= prod_q + IDX_W'(1);
      if (cons_wr_i) cons_q <= cons_idx_i;
      if (free <= LO_L)      xoff_q <= 1'b1;
      else if (free >= HI_L) xoff_q <= 1'b0;
    end
  end

  a_r5_prod_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prod_q != $past(prod_q)) |-> (prod_q == $past(prod_q) + IDX_W'(1)));
  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, used} <= RING_L);
  a_r6_commit_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> !full_o);
  a_r8_xoff_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xoff_q) |-> ($past(free) <= LO_L));
  a_r8_xoff_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(xoff_q) |-> ($past(free) >= HI_L));
endmodule

// File: rtl/rx_frame_wr.sv
module rx_frame_wr #(
  parameter int MAX_LEN = 1536,
  parameter int BUF_LEN = 2048,
  parameter int SLOT_W  = 8,
  parameter int CNT_W   = 12,
  parameter int PAD     = 2,
  localparam int OFF_W  = $clog2(BUF_LEN)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [7:0]              data_i,
  input  logic                    last_i,
  input  logic                    align_i,
  input  logic                    full_i,
  input  logic [SLOT_W-1:0]       slot_i,
  output logic                    mem_we_o,
  output logic [SLOT_W+OFF_W-1:0] mem_addr_o,
  output logic [7:0]              mem_data_o,
  output logic                    commit_o,
  output logic [CNT_W-1:0]        commit_len_o,
  output logic [15:0]             ovf_cnt_o
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_LEN);
  localparam logic [CNT_W-1:0] PAD_C = CNT_W'(PAD);

  logic             busy_q, drop_q, pad_q, long_q;
  logic [CNT_W-1:0] cnt_q, idx, len;
  logic [15:0]      ovf_q;
  logic             start, drop_now, pad_now, over, long_now;
  logic [OFF_W-1:0] off;

  always_comb begin
    start    = valid_i && !busy_q;
    drop_now = busy_q ? drop_q : full_i;
    pad_now  = busy_q ? pad_q : align_i;
    idx      = busy_q ? cnt_q : '0;
    over     = idx >= MAX_C;
    long_now = (busy_q && long_q) || over;
    off      = OFF_W'(idx) + (pad_now ? OFF_W'(PAD) : '0);
    len      = idx + CNT_W'(1) + (pad_now ? PAD_C : '0);
  end

  assign mem_we_o     = valid_i && !drop_now && !over;
  assign mem_addr_o   = {slot_i, off};
  assign mem_data_o   = data_i;
  assign commit_o     = valid_i && last_i && !drop_now && !long_now;
  assign commit_len_o = len;
  assign ovf_cnt_o    = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      drop_q <= 1'b0;
      pad_q  <= 1'b0;
      long_q <= 1'b0;
      cnt_q  <= '0;
      ovf_q  <= '0;
    end else if (valid_i) begin
      busy_q <= !last_i;
      long_q <= long_now;
      cnt_q  <= over ? idx : idx + CNT_W'(1);
      if (start) begin
        drop_q <= full_i;
        pad_q  <= align_i;
        if (full_i) ovf_q <= ovf_q + 16'd1;
      end
    end
  end

  a_r7_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (commit_len_o <= MAX_C + PAD_C));
  a_r2_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && busy_q && $past(mem_we_o)) |-> (off == $past(off) + OFF_W'(1)));
  a_r6_ovf_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q != $past(ovf_q)) |-> $past(start && full_i));
endmodule

// File: rtl/rx_desc_ram.sv
module rx_desc_ram #(
  parameter int DEPTH = 256,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma #(
  parameter int          RING     = 256,
  parameter int          BUF_LEN  = 2048,
  parameter int          MAX_LEN  = 1536,
  parameter int          XOFF_LO  = 5,
  parameter logic [15:0] PROD_RST = 16'hFFF0,
  localparam int SLOT_W = $clog2(RING),
  localparam int OFF_W  = $clog2(BUF_LEN),
  localparam int ADDR_W = SLOT_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_last_i,
  input  logic              align_en_i,
  input  logic              cons_wr_i,
  input  logic [15:0]       cons_idx_i,
  input  logic [SLOT_W-1:0] desc_idx_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o,
  output logic [31:0]       desc_word_o,
  output logic [15:0]       prod_idx_o,
  output logic              xoff_o,
  output logic [15:0]       ovf_cnt_o
);
  import rxdma_pkg::*;

  localparam int XON_HI = RING / 16;

  logic              commit, full;
  logic [LEN_W-1:0]  commit_len;

  rx_idx_ctrl #(
    .RING(RING), .IDX_W(16), .XOFF_LO(XOFF_LO), .XON_HI(XON_HI), .PROD_RST(PROD_RST)
  ) u_idx (
    .clk_i, .rst_ni,
    .commit_i   (commit),
    .cons_wr_i  (cons_wr_i),
    .cons_idx_i (cons_idx_i),
    .prod_o     (prod_idx_o),
    .full_o     (full),
    .xoff_o     (xoff_o)
  );

  rx_frame_wr #(
    .MAX_LEN(MAX_LEN), .BUF_LEN(BUF_LEN), .SLOT_W(SLOT_W), .CNT_W(LEN_W), .PAD(2)
  ) u_wr (
    .clk_i, .rst_ni,
    .valid_i      (rx_valid_i),
    .data_i       (rx_data_i),
    .last_i       (rx_last_i),
    .align_i      (align_en_i),
    .full_i       (full),
    .slot_i       (prod_idx_o[SLOT_W-1:0]),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_data_o   (mem_data_o),
    .commit_o     (commit),
    .commit_len_o (commit_len),
    .ovf_cnt_o    (ovf_cnt_o)
  );

  rx_desc_ram #(.DEPTH(RING), .W(32)) u_desc (
    .clk_i,
    .we_i    (commit),
    .waddr_i (prod_idx_o[SLOT_W-1:0]),
    .wdata_i (pack_status(commit_len)),
    .raddr_i (desc_idx_i),
    .rdata_o (desc_word_o)
  );

  a_r4_commit_on_frame_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> (rx_valid_i && rx_last_i));
endmodule

// File: tb/tb_rx_ring_dma.sv
module tb_rx_ring_dma;
  localparam int MAXL = 1536;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        rx_valid = 0, rx_last = 0, align_en = 0, cons_wr = 0;
  logic [7:0]  rx_data = 0, desc_idx = 0;
  logic [15:0] cons_idx = 0;
  logic        mem_we, xoff;
  logic [18:0] mem_addr;
  logic [7:0]  mem_data;
  logic [31:0] desc_word;
  logic [15:0] prod_idx, ovf_cnt;

  int total = 0, bad = 0;
  logic [15:0] prod_m = 16'hFFF0, cons_m = 16'hFFF0, ovf_m = 0;
  bit xoff_m = 0;
  logic [7:0] mem_m [int];

  always #10 clk = ~clk;

  rx_ring_dma dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_last_i(rx_last), .align_en_i(align_en), .cons_wr_i(cons_wr), .cons_idx_i(cons_idx),
    .desc_idx_i(desc_idx), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .desc_word_o(desc_word), .prod_idx_o(prod_idx), .xoff_o(xoff), .ovf_cnt_o(ovf_cnt)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int free_slots();
    logic [15:0] u;
    u = prod_m - cons_m;
    return 256 - int'(u);
  endfunction

  function automatic void upd_xoff();
    int f;
    f = free_slots();
    if (f <= 5) xoff_m = 1;
    else if (f >= 16) xoff_m = 0;
  endfunction

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed + 8'(i * 7);
  endfunction

  task automatic send(input int len, input bit al, input bit flip, input logic [7:0] seed);
    int wr = 0, miss = 0, base;
    bit full, lng;
    logic [7:0] slot;
    slot = prod_m[7:0];
    full = free_slots() <= 0;
    lng  = len > MAXL;
    mem_m.delete();
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = pat(seed, i); rx_last = (i == len - 1);
      align_en = (i == 0) ? al : (flip ? !al : al);
      #2;
      if (mem_we) begin wr++; mem_m[int'(mem_addr)] = mem_data; end
    end
    @(negedge clk);
    rx_valid = 0; rx_last = 0; desc_idx = slot;
    #2;
    if (full) begin
      ovf_m++;
      chk(wr == 0, "R6 no write when full", wr, 0);
      chk(ovf_cnt == ovf_m, "R6 overflow count", ovf_cnt, ovf_m);
    end else if (lng) begin
      chk(wr == MAXL, "R7 long frame writes stop", wr, MAXL);
    end else begin
      base = int'(slot) * 2048 + (al ? 2 : 0);
      for (int i = 0; i < len; i++)
        if (!mem_m.exists(base + i) || mem_m[base + i] != pat(seed, i)) miss++;
      chk(miss == 0, al ? (flip ? "R9 align sampled once" : "R3 aligned data") : "R2 data placement", miss, 0);
      chk(wr == len, "R3 pad bytes untouched / R2 one write per byte", wr, len);
      chk(desc_word == {4'b0, 12'(len + (al ? 2 : 0)), 1'b0, 1'b1, 1'b1, 13'b0},
          "R4 descriptor word", desc_word, {4'b0, 12'(len + (al ? 2 : 0)), 3'b011, 13'b0});
      prod_m++;
    end
    chk(prod_idx == prod_m, "R5 producer index", prod_idx, prod_m);
    @(negedge clk); #2;
    upd_xoff();
    chk(xoff == xoff_m, "R8 xoff level", xoff, xoff_m);
  endtask

  task automatic cons_write(input logic [15:0] v);
    @(negedge clk);
    cons_wr = 1; cons_idx = v;
    @(negedge clk);
    cons_wr = 0; cons_m = v;
    @(negedge clk); #2;
    upd_xoff();
    chk(xoff == xoff_m, "R10 consumer write / R8 xoff", xoff, xoff_m);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #2;
    chk(prod_idx == 16'hFFF0, "R1 reset producer", prod_idx, 16'hFFF0);
    chk(xoff == 0, "R1 reset xoff", xoff, 0);
    chk(ovf_cnt == 0, "R1 reset overflow", ovf_cnt, 0);
    rst_n = 1;

    send(60, 0, 0, 8'h11);
    send(33, 1, 0, 8'h22);
    send(20, 1, 1, 8'h33);
    send(20, 0, 1, 8'h44);
    send(1, 0, 0, 8'h55);
    send(MAXL, 0, 0, 8'h66);
    send(MAXL + 1, 0, 0, 8'h77);
    send(MAXL, 1, 0, 8'h88);
    send(MAXL + 1, 1, 0, 8'h99);

    // fill the ring, crossing the 16-bit wrap and both thresholds
    while (free_slots() > 0)
      send(1 + int'($urandom % 4), 1'($urandom), 0, 8'($urandom));
    chk(xoff == 1, "R8 xoff when ring full", xoff, 1);
    send(5, 0, 0, 8'hA5);
    send(3, 1, 0, 8'h5A);
    cons_write(cons_m + 16'd10);
    chk(xoff == 1, "R8 hold between thresholds", xoff, 1);
    cons_write(cons_m + 16'd6);
    chk(xoff == 0, "R8 xon at 16 free", xoff, 0);

    for (int n = 0; n < 150; n++) begin
      if ($urandom % 3 == 0) begin
        logic [15:0] u;
        u = prod_m - cons_m;
        cons_write(cons_m + 16'($urandom % (int'(u) + 1)));
      end
      send(1 + int'($urandom % 80), 1'($urandom), 1'($urandom), 8'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule